// File: doc/BRIEF.md
# PWM Timer with Graceful Stop

This block is a single-channel pulse-width timer. Software programs a period count and a high-time count, then starts the timer with an enable strobe. Each period drives the output high for the high-time count and low for the rest of the period. A configuration register selects one of two variants. In one-shot form, the timer emits one period and halts by itself. In repeating form, it runs period after period until software asks it to stop.

A stop request never cuts a waveform short. The disable strobe only drops the enable latch. The running flag stays at 1, and the output keeps its pattern until the period in progress is complete; only then does the timer go idle. Software can tell when the timer has halted by polling the running flag or by waiting for the period-end interrupt flag, which rises on the same cycle that the running flag falls. Configuration writes are rejected while the timer runs. New period and high-time values are picked up at the start of the next period. A setting that cannot produce a pulse raises a sticky error flag and produces no output.

All inputs are plain, single-cycle strobes or level signals sampled on the rising clock edge. There is no data stream, so there is no handshake at the block's edge.

Top module: `pwm_gstop`

## Requirements
- R1: After a synchronous reset, pwm_o, enabled_o, running_o, irq_o, err_o, cfg_cont_o and cfg_irq_en_o are all 0, and the programmed period and high-time counts are 0.
- R2: An en_set_i strobe taken while the timer is idle, with a legal setting, sets running_o and enabled_o at that edge. From that edge on, pwm_o is 1 for the first wid cycles of each period and 0 for the remaining per minus wid cycles.
- R3: In one-shot form (cfg_cont_o = 0), running_o and enabled_o both fall at the edge that ends the first period, with no disable strobe. A further pulse needs a new en_set_i strobe after the timer has halted.
- R4: In repeating form (cfg_cont_o = 1), the timer starts a new period directly after each period while the enable latch is set, and running_o stays 1 across the boundary.
- R5: A dis_set_i strobe taken while the timer runs clears enabled_o at that edge. running_o stays 1, and pwm_o keeps its pattern until the current period ends. running_o falls at the edge that ends that period and at no other edge. If the enable and disable strobes arrive together, the disable wins.
- R6: If the enable latch is cleared and then set again with en_set_i before the current period ends, the timer carries on into the next period without a gap.
- R7: A cfg_wr_i write updates cfg_cont_o and cfg_irq_en_o only while running_o is 0. While the timer runs, the write is ignored.
- R8: A setting is legal when the high-time count is nonzero and strictly smaller than the period count. It is checked at a start and at every period boundary. An illegal setting raises err_o, leaves or puts the timer idle with pwm_o at 0, and clears the enable latch. err_o holds until an err_clr_i strobe.
- R9: When cfg_irq_en_o is 1, irq_o is set at every period end. An irq_clr_i strobe clears it, but a set on the same edge wins. When the timer stops, irq_o rises on the same edge that running_o falls.
- R10: While the timer is idle, pwm_o stays at 0. A dis_set_i strobe taken while idle has no effect on enabled_o, running_o or pwm_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_set_i | input | 1 | Strobe that sets the enable latch (starts the timer when idle) |
| dis_set_i | input | 1 | Strobe that clears the enable latch (stop request) |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_cont_i | input | 1 | Variant to write: 0 one-shot, 1 repeating |
| cfg_irq_en_i | input | 1 | Period-end interrupt enable to write |
| per_wr_i | input | 1 | Period count write strobe |
| per_i | input | CNT_W | Period count in cycles |
| wid_wr_i | input | 1 | High-time count write strobe |
| wid_i | input | CNT_W | High-time count in cycles |
| irq_clr_i | input | 1 | Write-one-to-clear for irq_o |
| err_clr_i | input | 1 | Write-one-to-clear for err_o |
| pwm_o | output | 1 | Waveform output, 0 when idle |
| enabled_o | output | 1 | Enable latch readback |
| running_o | output | 1 | Timer active flag |
| irq_o | output | 1 | Period-end interrupt flag |
| err_o | output | 1 | Illegal setting flag |
| cfg_cont_o | output | 1 | Variant readback |
| cfg_irq_en_o | output | 1 | Interrupt enable readback |

## Verification
The bench places a disable strobe in the middle of a repeating period. It checks that enabled_o drops at once while running_o and the waveform carry on to the exact boundary. A design that halted on the strobe would cut the low phase short, and one that stopped a period late would show an extra high pulse. The bench also drops and then raises the enable latch inside one period, where a design that treated the disable as final would stop at the boundary. Further checks cover one-shot self-halting with no disable, configuration writes during a run (a missing lockout changes the readback), and high-time values of zero or equal to the period, which must flag an error rather than start the timer.

// File: rtl/pwm_gstop_pkg.sv
package pwm_gstop_pkg;
  typedef struct packed {
    logic cont;
    logic irq_en;
  } cfg_t;
endpackage

// File: rtl/pwm_gstop_cfg.sv
module pwm_gstop_cfg
  import pwm_gstop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic wr,
  input  cfg_t wdata,
  output cfg_t cfg
);
  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr && !running) begin
      cfg_q <= wdata;
    end
  end

  assign cfg = cfg_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst) running |=> $stable(cfg_q)); // R7
endmodule

// File: rtl/pwm_gstop_cnt.sv
module pwm_gstop_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] wid,
  output logic             last,
  output logic             legal,
  output logic             pwm
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] act_per;
  logic [CNT_W-1:0] act_wid;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_per <= '0;
      act_wid <= '0;
      cnt     <= '0;
    end else if (load) begin
      act_per <= per;
      act_wid <= wid;
      cnt     <= '0;
    end else if (run && !last) begin
      cnt <= cnt + ONE;
    end
  end

  assign legal = (wid != '0) && (wid < per);
  assign last  = (cnt == act_per - ONE);
  assign pwm   = run && (cnt < act_wid);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst) (run && !load) |-> (cnt < act_per)); // R2
endmodule

// File: rtl/pwm_gstop_ctrl.sv
module pwm_gstop_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic en_set,
  input  logic dis_set,
  input  logic irq_clr,
  input  logic err_clr,
  input  logic cont,
  input  logic irq_en,
  input  logic last,
  input  logic legal,
  output logic load,
  output logic running,
  output logic enabled,
  output logic irq,
  output logic err
);
  logic run_q, en_q, irq_q, err_q;
  logic en_nxt, start_ok, start_bad, end_cyc, go_on;

  always_comb begin
    en_nxt    = dis_set ? 1'b0 : (en_set ? 1'b1 : en_q);
    start_ok  = !run_q && en_set && !dis_set && legal;
    start_bad = !run_q && en_set && !dis_set && !legal;
    end_cyc   = run_q && last;
    go_on     = end_cyc && cont && en_nxt;
    load      = start_ok || (go_on && legal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (!run_q) begin
        if (start_ok) begin
          run_q <= 1'b1;
          en_q  <= 1'b1;
        end
      end else if (end_cyc) begin
        if (go_on && legal) begin
          en_q <= 1'b1;
        end else begin
          run_q <= 1'b0;
          en_q  <= 1'b0;
        end
      end else begin
        en_q <= en_nxt;
      end

      if (start_bad || (go_on && !legal)) err_q <= 1'b1;
      else if (err_clr)                   err_q <= 1'b0;

      if (end_cyc && irq_en) irq_q <= 1'b1;
      else if (irq_clr)      irq_q <= 1'b0;
    end
  end

  assign running = run_q;
  assign enabled = en_q;
  assign irq     = irq_q;
  assign err     = err_q;

  AST_STOP_AT_PERIOD_END: assert property (@(posedge clk) disable iff (rst) $fell(run_q) |-> $past(last)); // R5
  AST_DISABLE_DROPS_EN: assert property (@(posedge clk) disable iff (rst) (run_q && dis_set) |=> !en_q); // R5
  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (rst) (run_q && last && !cont) |=> (!run_q && !en_q)); // R3
  AST_IRQ_WITH_STOP: assert property (@(posedge clk) disable iff (rst) ($fell(run_q) && $past(irq_en)) |-> irq_q); // R9
endmodule

// File: rtl/pwm_gstop.sv
module pwm_gstop
  import pwm_gstop_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_set_i,
  input  logic             dis_set_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_cont_i,
  input  logic             cfg_irq_en_i,
  input  logic             per_wr_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             wid_wr_i,
  input  logic [CNT_W-1:0] wid_i,
  input  logic             irq_clr_i,
  input  logic             err_clr_i,
  output logic             pwm_o,
  output logic             enabled_o,
  output logic             running_o,
  output logic             irq_o,
  output logic             err_o,
  output logic             cfg_cont_o,
  output logic             cfg_irq_en_o
);
  logic [CNT_W-1:0] per_q, wid_q;
  cfg_t cfg, cfg_wdata;
  logic last, legal, load, running, pwm;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      wid_q <= '0;
    end else begin
      if (per_wr_i) per_q <= per_i;
      if (wid_wr_i) wid_q <= wid_i;
    end
  end

  assign cfg_wdata = '{cont: cfg_cont_i, irq_en: cfg_irq_en_i};

  pwm_gstop_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .running (running),
    .wr      (cfg_wr_i),
    .wdata   (cfg_wdata),
    .cfg     (cfg)
  );

  pwm_gstop_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (running),
    .load  (load),
    .per   (per_q),
    .wid   (wid_q),
    .last  (last),
    .legal (legal),
    .pwm   (pwm)
  );

  pwm_gstop_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en_set  (en_set_i),
    .dis_set (dis_set_i),
    .irq_clr (irq_clr_i),
    .err_clr (err_clr_i),
    .cont    (cfg.cont),
    .irq_en  (cfg.irq_en),
    .last    (last),
    .legal   (legal),
    .load    (load),
    .running (running),
    .enabled (enabled_o),
    .irq     (irq_o),
    .err     (err_o)
  );

  assign running_o    = running;
  assign pwm_o        = pwm;
  assign cfg_cont_o   = cfg.cont;
  assign cfg_irq_en_o = cfg.irq_en;

  AST_IDLE_OUTPUT_LOW: assert property (@(posedge clk) disable iff (rst) !running |-> !pwm); // R10
endmodule

// File: tb/pwm_gstop_tb_top.sv
module pwm_gstop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_set_i = 0, dis_set_i = 0, cfg_wr_i = 0, cfg_cont_i = 0, cfg_irq_en_i = 0;
  logic per_wr_i = 0, wid_wr_i = 0, irq_clr_i = 0, err_clr_i = 0;
  logic [CNT_W-1:0] per_i = '0, wid_i = '0;
  logic pwm_o, enabled_o, running_o, irq_o, err_o, cfg_cont_o, cfg_irq_en_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_gstop #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .en_set_i(en_set_i), .dis_set_i(dis_set_i),
    .cfg_wr_i(cfg_wr_i), .cfg_cont_i(cfg_cont_i), .cfg_irq_en_i(cfg_irq_en_i),
    .per_wr_i(per_wr_i), .per_i(per_i), .wid_wr_i(wid_wr_i), .wid_i(wid_i),
    .irq_clr_i(irq_clr_i), .err_clr_i(err_clr_i), .pwm_o(pwm_o),
    .enabled_o(enabled_o), .running_o(running_o), .irq_o(irq_o), .err_o(err_o),
    .cfg_cont_o(cfg_cont_o), .cfg_irq_en_o(cfg_irq_en_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_en();  en_set_i = 1;  step(); en_set_i = 0;  endtask
  task automatic pulse_dis(); dis_set_i = 1; step(); dis_set_i = 0; endtask
  task automatic pulse_irq_clr(); irq_clr_i = 1; step(); irq_clr_i = 0; endtask
  task automatic pulse_err_clr(); err_clr_i = 1; step(); err_clr_i = 0; endtask

  task automatic set_cfg(input logic cont, input logic ien);
    cfg_cont_i = cont; cfg_irq_en_i = ien; cfg_wr_i = 1; step(); cfg_wr_i = 0;
  endtask

  task automatic set_timing(input int per, input int wid);
    per_i = per; wid_i = wid; per_wr_i = 1; wid_wr_i = 1; step();
    per_wr_i = 0; wid_wr_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && running_o; i++) step();
  endtask

  task automatic t_reset();
    check("R1", "pwm", pwm_o, 0);
    check("R1", "enabled", enabled_o, 0);
    check("R1", "running", running_o, 0);
    check("R1", "irq", irq_o, 0);
    check("R1", "err", err_o, 0);
    check("R1", "cfg", {cfg_cont_o, cfg_irq_en_o}, 0);
  endtask

  task automatic t_idle_disable();
    pulse_dis();
    for (int i = 0; i < 3; i++) begin
      check("R10", "idle pwm", pwm_o, 0);
      check("R10", "idle enabled", enabled_o, 0);
      check("R10", "idle running", running_o, 0);
      step();
    end
  endtask

  task automatic t_oneshot();
    set_cfg(1'b0, 1'b1);
    check("R7", "cfg accepted when idle", {cfg_cont_o, cfg_irq_en_o}, 1);
    set_timing(5, 2);
    pulse_en();
    for (int j = 0; j < 5; j++) begin
      check("R2", "oneshot pwm", pwm_o, (j < 2) ? 1 : 0);
      check("R3", "oneshot running", running_o, 1);
      check("R3", "oneshot enabled", enabled_o, 1);
      step();
    end
    check("R3", "self halt running", running_o, 0);
    check("R3", "self halt enabled", enabled_o, 0);
    check("R9", "irq at end", irq_o, 1);
    check("R10", "pwm after halt", pwm_o, 0);
    step();
    check("R3", "no restart without strobe", running_o, 0);
    pulse_irq_clr();
    check("R9", "irq w1c", irq_o, 0);
    pulse_en();
    check("R3", "second pulse starts", running_o, 1);
    check("R3", "second pulse pwm", pwm_o, 1);
    wait_idle();
    pulse_irq_clr();
  endtask

  task automatic t_cont_stop();
    set_cfg(1'b1, 1'b1);
    set_timing(4, 1);
    pulse_en();
    for (int j = 0; j < 6; j++) begin
      check("R4", "cont pwm", pwm_o, ((j % 4) == 0) ? 1 : 0);
      check("R4", "cont running", running_o, 1);
      if (j < 5) step();
    end
    pulse_dis();
    check("R5", "enabled drops", enabled_o, 0);
    check("R5", "still running", running_o, 1);
    check("R5", "pwm continues low", pwm_o, 0);
    pulse_irq_clr();
    check("R5", "running final cycle", running_o, 1);
    check("R9", "irq cleared", irq_o, 0);
    step();
    check("R5", "stopped at boundary", running_o, 0);
    check("R9", "irq with stop", irq_o, 1);
    check("R5", "no extra pulse", pwm_o, 0);
    pulse_irq_clr();
  endtask

  task automatic t_reenable();
    set_cfg(1'b1, 1'b0);
    set_timing(4, 1);
    pulse_en();
    step();
    pulse_dis();
    check("R6", "latch cleared", enabled_o, 0);
    check("R6", "running kept", running_o, 1);
    pulse_en();
    check("R6", "latch set again", enabled_o, 1);
    step();
    check("R6", "runs across boundary", running_o, 1);
    check("R6", "new period high", pwm_o, 1);
    cfg_cont_i = 0; cfg_irq_en_i = 1; cfg_wr_i = 1; step(); cfg_wr_i = 0;
    check("R7", "cfg locked while running", {cfg_cont_o, cfg_irq_en_o}, 2);
    en_set_i = 1; dis_set_i = 1; step(); en_set_i = 0; dis_set_i = 0;
    check("R5", "disable beats enable", enabled_o, 0);
    wait_idle();
    check("R5", "halted after stop", running_o, 0);
    check("R9", "no irq when disabled", irq_o, 0);
    set_cfg(1'b0, 1'b1);
    check("R7", "cfg accepted after stop", {cfg_cont_o, cfg_irq_en_o}, 1);
  endtask

  task automatic t_illegal();
    set_timing(4, 0);
    pulse_en();
    check("R8", "zero width err", err_o, 1);
    check("R8", "zero width not running", running_o, 0);
    check("R8", "zero width enabled", enabled_o, 0);
    check("R8", "zero width pwm", pwm_o, 0);
    pulse_err_clr();
    check("R8", "err w1c", err_o, 0);
    set_timing(4, 4);
    pulse_en();
    check("R8", "width=period err", err_o, 1);
    check("R8", "width=period not running", running_o, 0);
    pulse_err_clr();
    set_timing(4, 3);
    pulse_en();
    check("R8", "legal starts", running_o, 1);
    check("R8", "legal no err", err_o, 0);
    wait_idle();
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_idle_disable();
    t_oneshot();
    t_cont_stop();
    t_reenable();
    t_illegal();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule